// File: doc/BRIEF.md
# Dual-Port Mailbox and Port Decode Controller

This block holds the control logic at both edges of a two-way FIFO pair that runs on two unrelated clocks. On each side it turns four qualifier inputs (active-low chip select, a direction select, an enable and a mailbox select) into at most one action per rising edge: push into the outgoing FIFO, pop the incoming FIFO, load the outgoing mailbox, or take the incoming mailbox. It also decides when the 36-bit data pins of that side are driven. When they are driven, it selects whether they show the FIFO output register or the incoming mailbox register. The FIFO memories are not part of this block. Their "has room" and "has data" flags and their output registers arrive as inputs, and the block returns single-cycle push and pop strobes.

Each direction has a one-word mailbox. The writing side loads it, and the receiving side sees an active-low "mail waiting" flag in its own clock domain. When the receiver takes the word, the flag returns high. A toggle-and-synchronise handshake carries each load forward to the receiver and each take back to the writer. The writer ignores further loads until the take of the earlier word has come back to its side, so a word is never overwritten before it is read and is never delivered twice.

Top module: `bimb_port_ctrl`

## Requirements
- R1: A side's data output enable is high exactly when its chip select is low and its direction select is low (read). While the enable is low, that side's data output is all zeros.
- R2: A side's FIFO push strobe is high exactly when chip select is low, direction select is high, enable is high, mailbox select is low and the outgoing FIFO reports room.
- R3: A side's FIFO pop strobe is high exactly when chip select is low, direction select is low, enable is high, mailbox select is low and the incoming FIFO reports data.
- R4: While the pins are driven, they show the incoming mailbox register when mailbox select is high and the FIFO output register when it is low, whatever the value of enable.
- R5: A mailbox load is chip select low, direction select high, enable high and mailbox select high. It captures the side's data input, and the receiver's mail flag goes low no later than SYNC_STAGES+2 receiver clocks after the loading edge.
- R6: A mailbox take is chip select low, direction select low, enable high and mailbox select high. A take while the receiver's flag is low sets the flag high at that edge. The flag then stays high until a new load arrives, so each word is delivered once. While no take occurs, a low flag stays low.
- R7: A load is ignored from the edge of an accepted load until the take of that word has been returned to the writer. The ignored word never reaches the receiver, and it raises no second flag.
- R8: With enable low, no push strobe, no pop strobe, no mailbox load and no mailbox take occurs.
- R9: After reset, both mail flags are high, both strobes on both sides are low, and both mailbox registers hold zero.
- R10: A take while the receiver's flag is already high has no effect. The flag stays high, and the next load is delivered normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side A clock |
| rst_a_n | input | 1 | Side A asynchronous reset, active low |
| a_cs_n | input | 1 | Side A chip select, active low |
| a_wr_sel | input | 1 | Side A direction: 1 write, 0 read |
| a_en | input | 1 | Side A enable |
| a_mbx | input | 1 | Side A mailbox select |
| a_din | input | 36 | Side A write data |
| a_dout | output | 36 | Side A read data (zero when not driven) |
| a_doe | output | 1 | Side A pin output enable |
| a_fifo_room | input | 1 | A-to-B FIFO can accept a word |
| a_fifo_avail | input | 1 | B-to-A FIFO holds a word |
| a_fifo_q | input | 36 | B-to-A FIFO output register |
| a_fifo_wr | output | 1 | Push strobe into A-to-B FIFO |
| a_fifo_rd | output | 1 | Pop strobe from B-to-A FIFO |
| a_mail_n | output | 1 | Mail waiting for side A, active low |
| clk_b | input | 1 | Side B clock |
| rst_b_n | input | 1 | Side B asynchronous reset, active low |
| b_cs_n | input | 1 | Side B chip select, active low |
| b_wr_sel | input | 1 | Side B direction: 1 write, 0 read |
| b_en | input | 1 | Side B enable |
| b_mbx | input | 1 | Side B mailbox select |
| b_din | input | 36 | Side B write data |
| b_dout | output | 36 | Side B read data (zero when not driven) |
| b_doe | output | 1 | Side B pin output enable |
| b_fifo_room | input | 1 | B-to-A FIFO can accept a word |
| b_fifo_avail | input | 1 | A-to-B FIFO holds a word |
| b_fifo_q | input | 36 | A-to-B FIFO output register |
| b_fifo_wr | output | 1 | Push strobe into B-to-A FIFO |
| b_fifo_rd | output | 1 | Pop strobe from A-to-B FIFO |
| b_mail_n | output | 1 | Mail waiting for side B, active low |

## Verification
The decode and the pin selection are combinational. An error there appears on the strobes or the pins in the same cycle as the input pattern, so every random vector checks them straight away. Errors in the mailbox state show up later and across domains. A toggle that is lost or doubled leaves the receiver's flag stuck low or raises it a second time. A bad busy state in the writer either drops a legal word or lets a second word overwrite a waiting one. The bench catches these because it bounds how long the flag may take to fall, checks that the flag stays high for several cycles after each take, and compares each delivered word with the last legal load.

// File: rtl/bimb_pkg.sv
`timescale 1ns/1ps
package bimb_pkg;
    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_FIFO_PUT,
        ACT_MAIL_PUT,
        ACT_FIFO_GET,
        ACT_MAIL_GET
    } port_act_e;
endpackage

// File: rtl/bimb_sync.sv
`timescale 1ns/1ps
module bimb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg_d, stg_q;

    always_comb begin
        stg_d = {stg_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/bimb_port_decode.sv
`timescale 1ns/1ps
module bimb_port_decode
    import bimb_pkg::*;
(
    input  logic      cs_n,
    input  logic      wr_sel,
    input  logic      en,
    input  logic      mbx,
    input  logic      room,
    input  logic      avail,
    output port_act_e act,
    output logic      drive,
    output logic      show_mail
);
    always_comb begin
        act = ACT_IDLE;
        if (!cs_n && en) begin
            unique case ({wr_sel, mbx})
                2'b10:   act = room  ? ACT_FIFO_PUT : ACT_IDLE;
                2'b11:   act = ACT_MAIL_PUT;
                2'b00:   act = avail ? ACT_FIFO_GET : ACT_IDLE;
                default: act = ACT_MAIL_GET;
            endcase
        end
        drive     = !cs_n && !wr_sel;
        show_mail = mbx;
    end
endmodule

// File: rtl/bimb_mailbox.sv
`timescale 1ns/1ps
module bimb_mailbox #(
    parameter int DATA_W      = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              put,
    input  logic [DATA_W-1:0] put_data,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              take,
    output logic [DATA_W-1:0] held_data,
    output logic              pending_n
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              req_tog;
        logic              busy;
        logic              ack_seen;
    } wr_state_t;

    typedef struct packed {
        logic req_seen;
        logic pend;
        logic ack_tog;
    } rd_state_t;

    wr_state_t w_d, w_q;
    rd_state_t r_d, r_q;
    logic      ack_s, req_s;

    bimb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(wclk), .rst_n(wrst_n), .d(r_q.ack_tog), .q(ack_s));

    bimb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(rclk), .rst_n(rrst_n), .d(w_q.req_tog), .q(req_s));

    // writer domain: load when idle, release when the take comes back
    always_comb begin
        w_d = w_q;
        if (w_q.busy) begin
            if (ack_s != w_q.ack_seen) begin
                w_d.busy     = 1'b0;
                w_d.ack_seen = ack_s;
            end
        end else if (put) begin
            w_d.data    = put_data;
            w_d.req_tog = ~w_q.req_tog;
            w_d.busy    = 1'b1;
        end
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) w_q <= '0;
        else         w_q <= w_d;
    end

    // reader domain: flag on arriving toggle, return a toggle on take
    always_comb begin
        r_d = r_q;
        if (req_s != r_q.req_seen) begin
            r_d.req_seen = req_s;
            r_d.pend     = 1'b1;
        end
        if (take && r_q.pend) begin
            r_d.pend    = 1'b0;
            r_d.ack_tog = ~r_q.ack_tog;
        end
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) r_q <= '0;
        else         r_q <= r_d;
    end

    // data is held stable by the writer from load until the take returns
    assign held_data = w_q.data;
    assign pending_n = ~r_q.pend;
endmodule

// File: rtl/bimb_port_ctrl.sv
`timescale 1ns/1ps
module bimb_port_ctrl
    import bimb_pkg::*;
#(
    parameter int DATA_W      = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_a,
    input  logic              rst_a_n,
    input  logic              a_cs_n,
    input  logic              a_wr_sel,
    input  logic              a_en,
    input  logic              a_mbx,
    input  logic [DATA_W-1:0] a_din,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_doe,
    input  logic              a_fifo_room,
    input  logic              a_fifo_avail,
    input  logic [DATA_W-1:0] a_fifo_q,
    output logic              a_fifo_wr,
    output logic              a_fifo_rd,
    output logic              a_mail_n,
    input  logic              clk_b,
    input  logic              rst_b_n,
    input  logic              b_cs_n,
    input  logic              b_wr_sel,
    input  logic              b_en,
    input  logic              b_mbx,
    input  logic [DATA_W-1:0] b_din,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_doe,
    input  logic              b_fifo_room,
    input  logic              b_fifo_avail,
    input  logic [DATA_W-1:0] b_fifo_q,
    output logic              b_fifo_wr,
    output logic              b_fifo_rd,
    output logic              b_mail_n
);
    port_act_e         a_act, b_act;
    logic              a_show_mail, b_show_mail;
    logic [DATA_W-1:0] ab_data, ba_data;

    bimb_port_decode u_dec_a (
        .cs_n(a_cs_n), .wr_sel(a_wr_sel), .en(a_en), .mbx(a_mbx),
        .room(a_fifo_room), .avail(a_fifo_avail),
        .act(a_act), .drive(a_doe), .show_mail(a_show_mail));

    bimb_port_decode u_dec_b (
        .cs_n(b_cs_n), .wr_sel(b_wr_sel), .en(b_en), .mbx(b_mbx),
        .room(b_fifo_room), .avail(b_fifo_avail),
        .act(b_act), .drive(b_doe), .show_mail(b_show_mail));

    bimb_mailbox #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_mb_ab (
        .wclk(clk_a), .wrst_n(rst_a_n),
        .put(a_act == ACT_MAIL_PUT), .put_data(a_din),
        .rclk(clk_b), .rrst_n(rst_b_n),
        .take(b_act == ACT_MAIL_GET),
        .held_data(ab_data), .pending_n(b_mail_n));

    bimb_mailbox #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_mb_ba (
        .wclk(clk_b), .wrst_n(rst_b_n),
        .put(b_act == ACT_MAIL_PUT), .put_data(b_din),
        .rclk(clk_a), .rrst_n(rst_a_n),
        .take(a_act == ACT_MAIL_GET),
        .held_data(ba_data), .pending_n(a_mail_n));

    always_comb begin
        a_fifo_wr = (a_act == ACT_FIFO_PUT);
        a_fifo_rd = (a_act == ACT_FIFO_GET);
        b_fifo_wr = (b_act == ACT_FIFO_PUT);
        b_fifo_rd = (b_act == ACT_FIFO_GET);
        a_dout    = !a_doe ? '0 : (a_show_mail ? ba_data : a_fifo_q);
        b_dout    = !b_doe ? '0 : (b_show_mail ? ab_data : b_fifo_q);
    end
endmodule

// File: rtl/bimb_port_ctrl_chk.sv
`timescale 1ns/1ps
module bimb_port_ctrl_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk_a,
    input logic              rst_a_n,
    input logic              a_cs_n,
    input logic              a_wr_sel,
    input logic              a_en,
    input logic              a_mbx,
    input logic [DATA_W-1:0] a_dout,
    input logic              a_doe,
    input logic              a_fifo_room,
    input logic              a_fifo_avail,
    input logic              a_fifo_wr,
    input logic              a_fifo_rd,
    input logic              a_mail_n,
    input logic              clk_b,
    input logic              rst_b_n,
    input logic              b_cs_n,
    input logic              b_wr_sel,
    input logic              b_en,
    input logic              b_mbx,
    input logic [DATA_W-1:0] b_dout,
    input logic              b_doe,
    input logic              b_fifo_room,
    input logic              b_fifo_avail,
    input logic              b_fifo_wr,
    input logic              b_fifo_rd,
    input logic              b_mail_n
);
    logic a_take, b_take;
    assign a_take = !a_cs_n && !a_wr_sel && a_en && a_mbx;
    assign b_take = !b_cs_n && !b_wr_sel && b_en && b_mbx;

    p_cs_float_a_r1: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        a_cs_n |-> (!a_doe && a_dout == '0));
    p_dir_float_b_r1: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        b_wr_sel |-> (!b_doe && b_dout == '0));
    p_push_qual_a_r2: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        a_fifo_wr |-> (a_fifo_room && a_wr_sel && !a_mbx && !a_fifo_rd));
    p_pop_qual_b_r3: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        b_fifo_rd |-> (b_fifo_avail && !b_wr_sel && !b_mbx && !b_fifo_wr));
    p_take_clears_b_r6: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (b_take && !b_mail_n) |=> b_mail_n);
    p_take_clears_a_r6: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (a_take && !a_mail_n) |=> a_mail_n);
    p_flag_holds_b_r6: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (!b_mail_n && !b_take) |=> !b_mail_n);
    p_flag_holds_a_r6: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (!a_mail_n && !a_take) |=> !a_mail_n);
    p_en_low_a_r8: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        !a_en |-> (!a_fifo_wr && !a_fifo_rd));
    p_en_low_b_r8: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        !b_en |-> (!b_fifo_wr && !b_fifo_rd));
endmodule

bind bimb_port_ctrl bimb_port_ctrl_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/bimb_port_ctrl_tb.sv
`timescale 1ns/1ps
module bimb_port_ctrl_tb_top;
    localparam int W    = 36;
    localparam int SYNC = 2;

    logic clk_a = 1'b0, clk_b = 1'b0;
    logic rst_a_n = 1'b0, rst_b_n = 1'b0;
    logic a_cs_n = 1'b1, a_wr_sel = 1'b1, a_en = 1'b0, a_mbx = 1'b0;
    logic b_cs_n = 1'b1, b_wr_sel = 1'b1, b_en = 1'b0, b_mbx = 1'b0;
    logic [W-1:0] a_din = '0, b_din = '0, a_fifo_q = '0, b_fifo_q = '0;
    logic a_fifo_room = 1'b0, a_fifo_avail = 1'b0;
    logic b_fifo_room = 1'b0, b_fifo_avail = 1'b0;
    logic [W-1:0] a_dout, b_dout;
    logic a_doe, b_doe, a_fifo_wr, a_fifo_rd, b_fifo_wr, b_fifo_rd;
    logic a_mail_n, b_mail_n;

    int vectors = 0, miscompares = 0;
    bit done = 1'b0;
    logic [W-1:0] mail_ab_v = '0, mail_ba_v = '0;

    always #5 clk_a = ~clk_a;
    always #7 clk_b = ~clk_b;

    bimb_port_ctrl #(.DATA_W(W), .SYNC_STAGES(SYNC)) dut_i (.*);

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_a(input logic cs_n, wr, en, mbx, input logic [W-1:0] d);
        a_cs_n = cs_n; a_wr_sel = wr; a_en = en; a_mbx = mbx; a_din = d;
    endtask

    task automatic set_b(input logic cs_n, wr, en, mbx, input logic [W-1:0] d);
        b_cs_n = cs_n; b_wr_sel = wr; b_en = en; b_mbx = mbx; b_din = d;
    endtask

    // expected {doe, push, pop, dout} from R1..R4 and R8
    function automatic logic [W+2:0] exp_port(input logic cs_n, wr, en, mbx,
            room, avail, input logic [W-1:0] q, input logic [W-1:0] mail);
        logic doe, push, pop;
        logic [W-1:0] d;
        doe  = !cs_n && !wr;
        push = !cs_n && wr && en && !mbx && room;
        pop  = !cs_n && !wr && en && !mbx && avail;
        d    = doe ? (mbx ? mail : q) : '0;
        return {doe, push, pop, d};
    endfunction

    task automatic rand_port_a(input int n);
        for (int i = 0; i < n; i++) begin
            logic [W+2:0] e;
            logic [3:0] r;
            @(negedge clk_a);
            r = 4'($urandom);
            if (r[3] && r[0]) r[0] = 1'b0; // no mailbox action in this phase
            set_a(r[1], r[2], r[0], r[3], W'({$urandom, $urandom}));
            a_fifo_room  = 1'($urandom); a_fifo_avail = 1'($urandom);
            a_fifo_q     = W'({$urandom, $urandom});
            #1;
            e = exp_port(a_cs_n, a_wr_sel, a_en, a_mbx, a_fifo_room,
                         a_fifo_avail, a_fifo_q, mail_ba_v);
            chk({a_doe, a_fifo_wr, a_fifo_rd, a_dout} == e, "R1/R2/R3/R4 port A",
                64'({a_doe, a_fifo_wr, a_fifo_rd, a_dout}), 64'(e));
        end
        @(negedge clk_a); set_a(1, 1, 0, 0, '0);
    endtask

    task automatic rand_port_b(input int n);
        for (int i = 0; i < n; i++) begin
            logic [W+2:0] e;
            logic [3:0] r;
            @(negedge clk_b);
            r = 4'($urandom);
            if (r[3] && r[0]) r[0] = 1'b0;
            set_b(r[1], r[2], r[0], r[3], W'({$urandom, $urandom}));
            b_fifo_room  = 1'($urandom); b_fifo_avail = 1'($urandom);
            b_fifo_q     = W'({$urandom, $urandom});
            #1;
            e = exp_port(b_cs_n, b_wr_sel, b_en, b_mbx, b_fifo_room,
                         b_fifo_avail, b_fifo_q, mail_ab_v);
            chk({b_doe, b_fifo_wr, b_fifo_rd, b_dout} == e, "R1/R2/R3/R4 port B",
                64'({b_doe, b_fifo_wr, b_fifo_rd, b_dout}), 64'(e));
        end
        @(negedge clk_b); set_b(1, 1, 0, 0, '0);
    endtask

    task automatic mail_ab(input logic [W-1:0] v);
        int n;
        @(negedge clk_a); set_a(0, 1, 1, 1, v);
        @(negedge clk_a); set_a(1, 1, 0, 0, '0);
        n = 0;
        while (b_mail_n && n < 20) begin @(negedge clk_b); n++; end
        chk(!b_mail_n && n <= SYNC + 3, "R5 A->B flag latency", 64'(n), 64'(SYNC + 3));
        set_b(0, 0, 0, 1, '0);
        @(negedge clk_b);
        chk(b_dout == v, "R4 B shows mailbox", 64'(b_dout), 64'(v));
        chk(!b_mail_n, "R8 en low no take B", 64'(b_mail_n), 64'(0));
        set_b(0, 0, 1, 1, '0);
        @(negedge clk_b); set_b(1, 1, 0, 0, '0);
        chk(b_mail_n, "R6 take clears B", 64'(b_mail_n), 64'(1));
        mail_ab_v = v;
        repeat (8) @(negedge clk_a);
    endtask

    task automatic mail_ba(input logic [W-1:0] v);
        int n;
        @(negedge clk_b); set_b(0, 1, 1, 1, v);
        @(negedge clk_b); set_b(1, 1, 0, 0, '0);
        n = 0;
        while (a_mail_n && n < 20) begin @(negedge clk_a); n++; end
        chk(!a_mail_n && n <= SYNC + 3, "R5 B->A flag latency", 64'(n), 64'(SYNC + 3));
        set_a(0, 0, 0, 1, '0);
        @(negedge clk_a);
        chk(a_dout == v, "R4 A shows mailbox", 64'(a_dout), 64'(v));
        chk(!a_mail_n, "R8 en low no take A", 64'(a_mail_n), 64'(0));
        set_a(0, 0, 1, 1, '0);
        @(negedge clk_a); set_a(1, 1, 0, 0, '0);
        chk(a_mail_n, "R6 take clears A", 64'(a_mail_n), 64'(1));
        mail_ba_v = v;
        repeat (8) @(negedge clk_b);
    endtask

    task automatic flag_b_stays_high(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk_b);
            chk(b_mail_n, req, 64'(b_mail_n), 64'(1));
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        vectors++; miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk_b);
        rst_a_n = 1'b1; rst_b_n = 1'b1;
        @(negedge clk_a);
        // R9 reset state
        chk(a_mail_n && b_mail_n, "R9 flags after reset", 64'({a_mail_n, b_mail_n}), 64'(3));
        chk(!a_fifo_wr && !a_fifo_rd && !b_fifo_wr && !b_fifo_rd, "R9 strobes after reset",
            64'({a_fifo_wr, a_fifo_rd, b_fifo_wr, b_fifo_rd}), 64'(0));
        set_a(0, 0, 0, 1, '0); #1;
        chk(a_doe && a_dout == '0, "R9 mailbox BA zero", 64'(a_dout), 64'(0));
        @(negedge clk_b); set_b(0, 0, 0, 1, '0); #1;
        chk(b_doe && b_dout == '0, "R9 mailbox AB zero", 64'(b_dout), 64'(0));
        set_a(1, 1, 0, 0, '0); set_b(1, 1, 0, 0, '0);

        // directed: cs high, all others active (R1, R2)
        @(negedge clk_a); set_a(1, 1, 1, 0, '1); a_fifo_room = 1'b1; #1;
        chk(!a_doe && !a_fifo_wr && a_dout == '0, "R1 R2 cs high idle",
            64'({a_doe, a_fifo_wr}), 64'(0));
        // R3: read with empty FIFO gives no pop
        set_a(0, 0, 1, 0, '0); a_fifo_avail = 1'b0; #1;
        chk(!a_fifo_rd && a_doe, "R3 no pop when empty", 64'(a_fifo_rd), 64'(0));
        set_a(1, 1, 0, 0, '0);

        rand_port_a(300);
        rand_port_b(300);

        // R5/R6 directed corners
        mail_ab(36'h0_0000_0001);
        mail_ba(36'hF_FFFF_FFFF);
        flag_b_stays_high(6, "R6 no second delivery");

        // R8: load pattern with enable low does nothing
        @(negedge clk_a); set_a(0, 1, 0, 1, 36'hA_BCDE_F012);
        repeat (3) @(negedge clk_a);
        set_a(1, 1, 0, 0, '0);
        flag_b_stays_high(6, "R8 en low no load");
        @(negedge clk_b); set_b(0, 0, 0, 1, '0); #1;
        chk(b_dout == mail_ab_v, "R8 mailbox unchanged", 64'(b_dout), 64'(mail_ab_v));
        set_b(1, 1, 0, 0, '0);

        // R10: take with flag high is a no-op
        @(negedge clk_b); set_b(0, 0, 1, 1, '0);
        @(negedge clk_b); set_b(1, 1, 0, 0, '0);
        flag_b_stays_high(6, "R10 empty take");
        mail_ab(36'h5_5555_AAAA);

        // R7: second load while the first is waiting is dropped
        @(negedge clk_a); set_a(0, 1, 1, 1, 36'h1_1111_1111);
        @(negedge clk_a); set_a(1, 1, 0, 0, '0);
        @(negedge clk_a); set_a(0, 1, 1, 1, 36'h2_2222_2222);
        @(negedge clk_a); set_a(1, 1, 0, 0, '0);
        for (int n = 0; n < 20 && b_mail_n; n++) @(negedge clk_b);
        chk(!b_mail_n, "R7 first word arrives", 64'(b_mail_n), 64'(0));
        set_b(0, 0, 0, 1, '0); #1;
        chk(b_dout == 36'h1_1111_1111, "R7 first word kept", 64'(b_dout), 64'h1_1111_1111);
        @(negedge clk_b); set_b(0, 0, 1, 1, '0);
        @(negedge clk_b); set_b(1, 1, 0, 0, '0);
        mail_ab_v = 36'h1_1111_1111;
        repeat (10) @(negedge clk_a);
        flag_b_stays_high(8, "R7 dropped word not delivered");
        mail_ab(36'h3_3333_3333);

        // random mailbox traffic both ways
        for (int i = 0; i < 30; i++) begin
            if ($urandom % 2) mail_ab(W'({$urandom, $urandom}));
            else              mail_ba(W'({$urandom, $urandom}));
        end
        rand_port_a(50);
        rand_port_b(50);
        finish_run();
    end
endmodule